// File: doc/BRIEF.md
# Calibration Pulse and Trigger Sequencer

This block turns calibration strobes into delayed test pulses for a group of front-end boards. It then follows each pulse with a trigger and a set of per-board match signals. Two strobe inputs drive two separate delay paths. The external-charge path ends in `ext_pls_o` and the injection path ends in `inj_pls_o`.

Each pulse path counts in fast-clock cycles, which are half a bunch crossing long. A pulse path can start a second countdown that counts in whole crossings, marked by the crossing-enable input. That second countdown ends in the trigger and the match fan-out.

Configuration inputs control the outputs:
- a calibration-mode bit decides whether pulses launch triggers;
- a mask bit silences the pulse lines;
- a kill vector removes the trigger line or single match lines;
- a cable-delay bit retards the trigger-side outputs by one crossing.

A one-cycle command write fires pulses, a test trigger or a bunch-crossing-zero marker by hand.

Top module: `calseq_top`

## Requirements
- R1: A rising edge on `cal_ext_stb_i` in cycle c, with `ext_dly_i` = d (0 to 31), drives `ext_pls_o` high for exactly one cycle, in cycle c+1+d.
- R2: The injection path behaves the same way, using `cal_inj_stb_i` and `inj_dly_i`, to drive `inj_pls_o`. It runs independently of the external path, including when both strobes rise in the same cycle.
- R3: A new rising edge on a strobe while its path is still counting restarts that path's count from the new edge. Only the pulse from the later edge appears.
- R4: Strobes are edge-detected. A strobe held high for several cycles yields a single pulse.
- R5: With `cal_mode_i` = 1, a pulse event in cycle p (from either path, or from a manual pulse command) sets `l1a_o` and the matches high for one cycle. That cycle is the one after the (T+1)-th cycle, counted from p inclusive, in which `bx_en_i` is high. T is the value of `trig_dly_i`.
- R6: With `cal_mode_i` = 0, pulses produce no trigger and no match.
- R7: `mask_pls_i` = 1 holds both `ext_pls_o` and `inj_pls_o` low. In calibration mode the masked pulse still launches its trigger.
- R8: Kill bit 0 blocks `l1a_o`. Kill bit i+1 blocks `l1a_match_o[i]` for i = 0 to 6. This applies to every trigger source.
- R9: A write with `man_wr_i` = 1 in cycle c acts in cycle c+1 according to the bits of `man_cmd_i`:
  - bit 0 fires an injection pulse;
  - bit 1 fires an external-charge pulse;
  - bit 2 fires a test trigger with matches, subject to kill;
  - bit 5 fires `bc0_o`;
  - bits 3 and 4 have no effect.
  Manual pulses obey the mask and launch triggers in calibration mode.
- R10: With `cable_dly_i` = 1, `l1a_o`, `l1a_match_o` and `bc0_o` appear two cycles (one crossing) later than without it. The pulse outputs are unaffected.
- R11: While reset is active, all outputs are low. Any count in progress when reset is asserted is discarded and produces no output afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two cycles per bunch crossing |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_en_i | input | 1 | Crossing enable, high in one cycle of each crossing |
| cal_ext_stb_i | input | 1 | Strobe that starts the external-charge path |
| cal_inj_stb_i | input | 1 | Strobe that starts the injection path |
| ext_dly_i | input | 5 | External-charge delay in fast cycles |
| inj_dly_i | input | 5 | Injection delay in fast cycles |
| trig_dly_i | input | 4 | Pulse-to-trigger delay in crossings |
| cal_mode_i | input | 1 | 1: every pulse launches a trigger |
| mask_pls_i | input | 1 | 1: suppress both pulse outputs |
| kill_i | input | 8 | Bit 0 blocks the trigger; bits 1 to 7 block the board matches |
| cable_dly_i | input | 1 | 1: delay trigger, matches and bc0 by one crossing |
| man_wr_i | input | 1 | Manual command write strobe |
| man_cmd_i | input | 6 | Manual command bits |
| ext_pls_o | output | 1 | External-charge pulse |
| inj_pls_o | output | 1 | Injection pulse |
| l1a_o | output | 1 | Trigger output |
| l1a_match_o | output | 7 | Per-board match outputs |
| bc0_o | output | 1 | Bunch-crossing-zero marker |

## Verification
The pulse paths are tested with the following delays:
- zero and the largest delay, which expose off-by-one errors in the counter load;
- simultaneous strobes on both paths, which separate path independence from a shared counter;
- a restart in mid-count and a strobe held high for several cycles, which distinguish edge detection from level sensing.

Trigger timing is checked with pulses on both parities of the crossing enable and with several trigger delays, up to the maximum. This separates crossing-aligned counting from plain cycle counting. Mask, kill, cable-delay, manual-command and reset cases each isolate one gating path while the scoreboard rejects any output at an unexpected cycle.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    // Path indices: which delay path belongs to which strobe and pulse
    localparam int IDX_EXT = 0;
    localparam int IDX_INJ = 1;

    // Manual command bit positions (decoded by the command logic)
    localparam int CMD_INJ  = 0;
    localparam int CMD_EXT  = 1;
    localparam int CMD_TL1A = 2;
    localparam int CMD_BC0  = 5;

    typedef enum logic [1:0] {
        CNT_IDLE   = 2'd0,
        CNT_RUN    = 2'd1,
        CNT_EXPIRE = 2'd2
    } cnt_phase_e;

endpackage

// File: rtl/calseq_dly_unit.sv
module calseq_dly_unit #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             fire_o
);
    import calseq_pkg::*;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } unit_st_t;

    unit_st_t   st_d, st_q;
    cnt_phase_e phase;

    // The start cycle counts as the first tick when the tick is present
    always_comb begin
        phase = CNT_IDLE;
        if (start_i) begin
            if (tick_i && (val_i == '0)) begin
                phase = CNT_EXPIRE;
            end else begin
                phase = CNT_RUN;
            end
        end else if (st_q.armed && tick_i) begin
            phase = (st_q.cnt == '0) ? CNT_EXPIRE : CNT_RUN;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        unique case (phase)
            CNT_EXPIRE: begin
                st_d.fire  = 1'b1;
                st_d.armed = 1'b0;
            end
            CNT_RUN: begin
                st_d.armed = 1'b1;
                if (start_i) begin
                    st_d.cnt = tick_i ? (val_i - CNT_W'(1)) : val_i;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = st_q.fire;

    AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> $past(tick_i)) else $error("fire without tick"); // R5

    AST_DISARM_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> !st_q.armed) else $error("still armed after fire"); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && $past(st_q.armed) && !$past(start_i) && $past(tick_i))
        |-> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1))) else $error("count step"); // R1

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !$past(tick_i) && !$past(start_i)) |-> $stable(st_q.cnt))
        else $error("count moved without tick"); // R5

endmodule

// File: rtl/calseq_fanout.sv
module calseq_fanout #(
    parameter int N_BOARD = 7,
    parameter int CAB_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_i,
    input  logic               bc0_i,
    input  logic               cable_i,
    input  logic [N_BOARD:0]   kill_i,
    output logic               l1a_o,
    output logic [N_BOARD-1:0] match_o,
    output logic               bc0_o
);

    typedef struct packed {
        logic [CAB_CYC-1:0] trig;
        logic [CAB_CYC-1:0] bc0;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  sel_trig;

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.trig[0] = trig_i;
        pipe_d.bc0[0]  = bc0_i;
        for (int i = 1; i < CAB_CYC; i++) begin
            pipe_d.trig[i] = pipe_q.trig[i-1];
            pipe_d.bc0[i]  = pipe_q.bc0[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign sel_trig = cable_i ? pipe_q.trig[CAB_CYC-1] : trig_i;
    assign bc0_o    = cable_i ? pipe_q.bc0[CAB_CYC-1]  : bc0_i;
    assign l1a_o    = sel_trig & ~kill_i[0];

    for (genvar b = 0; b < N_BOARD; b++) begin : g_match
        assign match_o[b] = sel_trig & ~kill_i[b+1];
    end

    AST_CABLE_BC0_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cable_i && bc0_o) |-> $past(bc0_i, CAB_CYC)) else $error("bc0 lag"); // R10

    AST_CABLE_TRIG_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cable_i && l1a_o) |-> $past(trig_i, CAB_CYC)) else $error("trigger lag"); // R10

endmodule

// File: rtl/calseq_top.sv
module calseq_top
    import calseq_pkg::*;
#(
    parameter int PDLY_W  = 5,
    parameter int TDLY_W  = 4,
    parameter int N_BOARD = 7,
    parameter int CAB_CYC = 2,
    parameter int CMD_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bx_en_i,
    input  logic                cal_ext_stb_i,
    input  logic                cal_inj_stb_i,
    input  logic [PDLY_W-1:0]   ext_dly_i,
    input  logic [PDLY_W-1:0]   inj_dly_i,
    input  logic [TDLY_W-1:0]   trig_dly_i,
    input  logic                cal_mode_i,
    input  logic                mask_pls_i,
    input  logic [N_BOARD:0]    kill_i,
    input  logic                cable_dly_i,
    input  logic                man_wr_i,
    input  logic [CMD_W-1:0]    man_cmd_i,
    output logic                ext_pls_o,
    output logic                inj_pls_o,
    output logic                l1a_o,
    output logic [N_BOARD-1:0]  l1a_match_o,
    output logic                bc0_o
);

    localparam int N_PATH = 2;

    typedef struct packed {
        logic [N_PATH-1:0] stb_prev;
        logic [N_PATH-1:0] man_pls;
        logic              man_l1a;
        logic              man_bc0;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [N_PATH-1:0] stb_now, stb_rise, path_fire, path_evt, trig_start, trig_fire;
    logic [PDLY_W-1:0] path_dly [N_PATH];
    logic              core_trig;

    always_comb begin
        stb_now[IDX_EXT]  = cal_ext_stb_i;
        stb_now[IDX_INJ]  = cal_inj_stb_i;
        path_dly[IDX_EXT] = ext_dly_i;
        path_dly[IDX_INJ] = inj_dly_i;
    end

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_now;
        st_d.man_pls  = '0;
        st_d.man_l1a  = 1'b0;
        st_d.man_bc0  = 1'b0;
        if (man_wr_i) begin
            st_d.man_pls[IDX_INJ] = man_cmd_i[CMD_INJ];
            st_d.man_pls[IDX_EXT] = man_cmd_i[CMD_EXT];
            st_d.man_l1a          = man_cmd_i[CMD_TL1A];
            st_d.man_bc0          = man_cmd_i[CMD_BC0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_rise   = stb_now & ~st_q.stb_prev;
    assign path_evt   = path_fire | st_q.man_pls;
    assign trig_start = path_evt & {N_PATH{cal_mode_i}};

    for (genvar g = 0; g < N_PATH; g++) begin : g_path
        calseq_dly_unit #(.CNT_W(PDLY_W)) u_pulse_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (stb_rise[g]),
            .tick_i  (1'b1),
            .val_i   (path_dly[g]),
            .fire_o  (path_fire[g])
        );
        calseq_dly_unit #(.CNT_W(TDLY_W)) u_trig_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (trig_start[g]),
            .tick_i  (bx_en_i),
            .val_i   (trig_dly_i),
            .fire_o  (trig_fire[g])
        );
    end

    assign ext_pls_o = path_evt[IDX_EXT] & ~mask_pls_i;
    assign inj_pls_o = path_evt[IDX_INJ] & ~mask_pls_i;
    assign core_trig = (|trig_fire) | st_q.man_l1a;

    calseq_fanout #(.N_BOARD(N_BOARD), .CAB_CYC(CAB_CYC)) u_fanout (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (core_trig),
        .bc0_i   (st_q.man_bc0),
        .cable_i (cable_dly_i),
        .kill_i  (kill_i),
        .l1a_o   (l1a_o),
        .match_o (l1a_match_o),
        .bc0_o   (bc0_o)
    );

    AST_MAN_BC0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(man_wr_i && man_cmd_i[CMD_BC0]) && !cable_dly_i) |-> bc0_o)
        else $error("manual bc0 missing"); // R9

endmodule

// File: tb/calseq_top_tb_top.sv
`timescale 1ns/1ps
module calseq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bx_en = 1'b0;
    logic       ext_stb = 1'b0, inj_stb = 1'b0;
    logic [4:0] ext_dly = '0, inj_dly = '0;
    logic [3:0] trig_dly = '0;
    logic       cal_mode = 1'b0, mask_pls = 1'b0, cable = 1'b0, man_wr = 1'b0;
    logic [7:0] kill = '0;
    logic [5:0] man_cmd = '0;
    logic       ext_pls, inj_pls, l1a, bc0;
    logic [6:0] match;

    int    cyc = 0;
    int    n_chk = 0, n_bad = 0;
    bit    done = 1'b0;
    string cur_tag = "R11";

    typedef struct {
        int       c;
        bit       ext;
        bit       inj;
        bit       l1a;
        bit [6:0] m;
        bit       bc0;
        string    tag;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    calseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .bx_en_i(bx_en),
        .cal_ext_stb_i(ext_stb), .cal_inj_stb_i(inj_stb),
        .ext_dly_i(ext_dly), .inj_dly_i(inj_dly), .trig_dly_i(trig_dly),
        .cal_mode_i(cal_mode), .mask_pls_i(mask_pls), .kill_i(kill),
        .cable_dly_i(cable), .man_wr_i(man_wr), .man_cmd_i(man_cmd),
        .ext_pls_o(ext_pls), .inj_pls_o(inj_pls), .l1a_o(l1a),
        .l1a_match_o(match), .bc0_o(bc0)
    );

    // cycle counter and crossing enable: high in even cycles
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        bx_en <= ((cyc + 1) % 2 == 0);
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_at(int c, bit e, bit i, bit l, bit [6:0] m, bit b, string tag);
        exp_t it;
        int   pos;
        it.c = c; it.ext = e; it.inj = i; it.l1a = l; it.m = m; it.bc0 = b; it.tag = tag;
        pos = sbq.size();
        for (int k = 0; k < sbq.size(); k++) begin
            if (sbq[k].c == c) begin
                sbq[k].ext = sbq[k].ext | e;
                sbq[k].inj = sbq[k].inj | i;
                sbq[k].l1a = sbq[k].l1a | l;
                sbq[k].m   = sbq[k].m | m;
                sbq[k].bc0 = sbq[k].bc0 | b;
                return;
            end
            if (sbq[k].c > c) begin
                pos = k;
                break;
            end
        end
        sbq.insert(pos, it);
    endtask

    // monitor: compare outputs against the scoreboard away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [10:0] obs, ev;
            exp_t        h;
            obs = {ext_pls, inj_pls, l1a, match, bc0};
            while (sbq.size() > 0 && sbq[0].c < cyc) begin
                h = sbq.pop_front();
                ev = {h.ext, h.inj, h.l1a, h.m, h.bc0};
                chk(1'b0, h.tag, $sformatf("missing event at cycle %0d", h.c), 0, int'(ev));
            end
            if (sbq.size() > 0 && sbq[0].c == cyc) begin
                h = sbq.pop_front();
                ev = {h.ext, h.inj, h.l1a, h.m, h.bc0};
                chk(obs == ev, h.tag, $sformatf("outputs at cycle %0d", cyc), int'(obs), int'(ev));
            end else if (obs != '0) begin
                chk(1'b0, cur_tag, $sformatf("unexpected output at cycle %0d", cyc), int'(obs), 0);
            end
        end
    end

    function automatic int trig_cycle(int p, int t, bit cab);
        int cnt = 0;
        for (int q = p; q < p + 100; q++) begin
            if (q % 2 == 0) begin
                if (cnt == t) return q + 1 + (cab ? 2 : 0);
                cnt++;
            end
        end
        return -1;
    endfunction

    task automatic exp_trig(int p, string tag);
        if (cal_mode)
            expect_at(trig_cycle(p, int'(trig_dly), cable), 0, 0, !kill[0], ~kill[7:1], 0, tag);
    endtask

    task automatic drain(string tag);
        int guard = 0;
        while (sbq.size() != 0 && guard < 300) begin
            step(1);
            guard++;
        end
        step(8);
        chk(sbq.size() == 0, tag, "scoreboard drained", sbq.size(), 0);
    endtask

    task automatic fire_ext(int d, int len, string tag);
        int c;
        cur_tag = tag;
        ext_dly = 5'(d);
        c = cyc;
        ext_stb = 1'b1;
        step(len);
        ext_stb = 1'b0;
        expect_at(c + 1 + d, !mask_pls, 0, 0, '0, 0, tag);
        exp_trig(c + 1 + d, tag);
        drain(tag);
    endtask

    task automatic fire_inj(int d, string tag);
        int c;
        cur_tag = tag;
        inj_dly = 5'(d);
        c = cyc;
        inj_stb = 1'b1;
        step(1);
        inj_stb = 1'b0;
        expect_at(c + 1 + d, 0, !mask_pls, 0, '0, 0, tag);
        exp_trig(c + 1 + d, tag);
        drain(tag);
    endtask

    task automatic man(logic [5:0] cmd, string tag);
        int c;
        int lag;
        cur_tag = tag;
        lag = cable ? 2 : 0;
        c = cyc;
        man_cmd = cmd;
        man_wr = 1'b1;
        step(1);
        man_wr = 1'b0;
        man_cmd = '0;
        expect_at(c + 1, cmd[1] & !mask_pls, cmd[0] & !mask_pls, 0, '0, 0, tag);
        if (cmd[2]) expect_at(c + 1 + lag, 0, 0, !kill[0], ~kill[7:1], 0, tag);
        if (cmd[5]) expect_at(c + 1 + lag, 0, 0, 0, '0, 1, tag);
        if (cmd[0] | cmd[1]) exp_trig(c + 1, tag);
        drain(tag);
    endtask

    // watchdog
    always @(posedge clk) begin
        if (!done && cyc > 60000) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 60000);
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        step(4);
        // R11: reset state
        chk({ext_pls, inj_pls, l1a, match, bc0} == '0, "R11", "outputs in reset", 
            int'({ext_pls, inj_pls, l1a, match, bc0}), 0);
        rst_n = 1'b1;
        step(3);

        // R1: external path delays, zero and maximum
        fire_ext(0, 1, "R1");
        fire_ext(31, 1, "R1");
        fire_ext(9, 1, "R1");
        // R2: injection path, alone and together with the external path
        fire_inj(7, "R2");
        cur_tag = "R2";
        ext_dly = 5'd5; inj_dly = 5'd2;
        c = cyc;
        ext_stb = 1'b1; inj_stb = 1'b1;
        step(1);
        ext_stb = 1'b0; inj_stb = 1'b0;
        expect_at(c + 6, 1, 0, 0, '0, 0, "R2");
        expect_at(c + 3, 0, 1, 0, '0, 0, "R2");
        drain("R2");

        // R3: restart in mid-count
        cur_tag = "R3";
        ext_dly = 5'd10;
        ext_stb = 1'b1;
        step(1);
        ext_stb = 1'b0;
        step(3);
        c = cyc;
        ext_stb = 1'b1;
        step(1);
        ext_stb = 1'b0;
        expect_at(c + 11, 1, 0, 0, '0, 0, "R3");
        drain("R3");

        // R4: strobe held high for three cycles
        fire_ext(2, 3, "R4");

        // R5: calibration-mode triggers on both crossing parities
        cal_mode = 1'b1;
        trig_dly = 4'd0;  fire_inj(0, "R5");
        trig_dly = 4'd0;  fire_inj(1, "R5");
        trig_dly = 4'd3;  fire_ext(4, 1, "R5");
        trig_dly = 4'd15; fire_ext(1, 1, "R5");
        trig_dly = 4'd2;  man(6'h01, "R5");

        // R6: nominal mode, no trigger
        cal_mode = 1'b0;
        trig_dly = 4'd1;
        fire_ext(3, 1, "R6");
        fire_inj(6, "R6");

        // R7: mask, trigger still launched in calibration mode
        mask_pls = 1'b1;
        cal_mode = 1'b1;
        fire_ext(3, 1, "R7");
        man(6'h02, "R7");
        mask_pls = 1'b0;
        cal_mode = 1'b0;

        // R8: kill patterns
        kill = 8'h05; man(6'h04, "R8");
        kill = 8'hFE; man(6'h04, "R8");
        kill = 8'h01; cal_mode = 1'b1; trig_dly = 4'd1; fire_inj(2, "R8");
        kill = 8'h00; cal_mode = 1'b0;

        // R9: manual commands
        man(6'h01, "R9");
        man(6'h02, "R9");
        man(6'h04, "R9");
        man(6'h20, "R9");
        man(6'h18, "R9");
        man(6'h27, "R9");

        // R10: cable delay
        cable = 1'b1;
        man(6'h24, "R10");
        cal_mode = 1'b1; trig_dly = 4'd1;
        fire_ext(2, 1, "R10");
        cal_mode = 1'b0;
        cable = 1'b0;

        // R11: reset discards a running count
        cur_tag = "R11";
        ext_dly = 5'd31;
        ext_stb = 1'b1;
        step(1);
        ext_stb = 1'b0;
        step(5);
        rst_n = 1'b0;
        step(2);
        chk({ext_pls, inj_pls, l1a, match, bc0} == '0, "R11", "outputs during reset",
            int'({ext_pls, inj_pls, l1a, match, bc0}), 0);
        rst_n = 1'b1;
        step(45);
        chk({ext_pls, inj_pls, l1a, match, bc0} == '0, "R11", "no pulse after reset",
            int'({ext_pls, inj_pls, l1a, match, bc0}), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule